// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI host read and write an internal byte-wide register file with an 11-bit address space. It runs on the chip's system clock. Chip select, serial clock and serial data in are brought through a short synchronizer, and serial clock edges are found by comparing successive samples. Each transaction opens when chip select goes low and closes when it goes high. The first two bytes carry a direction flag and the register address, both MSB first. A third byte then carries either the write data, from the host, or the read data, returned on SDO.

On the register side, the block drives an address, a write data byte, and a one-cycle write strobe or one-cycle read strobe. Read data comes back combinationally on a separate input. SDO comes with an output enable, which is held low everywhere outside the read data phase; the enable stands in for high impedance at the pad.

Top module: `spi_regacc`

## Requirements
- R1: After reset, and whenever chip select is high, sdo_oe, reg_we and reg_re are all low, even if the serial clock toggles.
- R2: SDI is sampled on rising SCLK edges, MSB first. Bit 0 of the frame (first byte, bit 7) is the direction: 1 = read, 0 = write.
- R3: reg_addr[10:8] come from bits 2..0 of the first byte and reg_addr[7:0] from the second byte. Bits 6..3 of the first byte have no effect.
- R4: A read frame produces exactly one single-cycle reg_re pulse, after the 16th rising edge, with reg_addr holding the decoded address.
- R5: On a read, the register byte leaves on SDO MSB first. Each bit changes on a falling SCLK edge and is valid at rising edges 16 to 23 (counted from 0).
- R6: sdo_oe rises on the falling edge after rising edge 15 of a read and falls on the falling edge after rising edge 23. It stays low throughout write frames.
- R7: On a write, rising edges 16 to 23 carry the data byte MSB first. Exactly one single-cycle reg_we pulse then follows, with reg_addr and reg_wdata set.
- R8: A frame in which chip select rises before 24 bits produces no reg_we, and the next frame decodes from its own first bit.
- R9: Rising edges after the 24th within one frame are ignored: no further strobe, and sdo_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idle low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host (low when not enabled) |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| reg_addr | output | 11 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 8 | Register read data, valid while reg_addr is held |

## Verification
Every SPI input passes two synchronizer stages and an edge-detect register, and the outputs are then registered. A result therefore appears about four system cycles after the SCLK edge that causes it. The bench holds each SCLK half period for eight system cycles and samples sdo and sdo_oe on the falling system clock at the end of the low half, just before it raises SCLK. Strobes are counted at every falling system clock and compared once chip select has been high for sixteen cycles, which leaves the write strobe time to complete. A read data byte is checked bit by bit at rising edges 16 to 23, against a bench copy of the register file that is updated only by completed writes.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
  localparam int CMD_BITS = 16;

  typedef struct packed {
    logic active;
    logic rise;
    logic fall;
    logic din;
  } spi_ev_t;
endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync
  import spi_regacc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n,
  input  logic    sclk,
  input  logic    sdi,
  output spi_ev_t ev
);
  localparam logic [2:0] IDLE_VAL = 3'b100;

  logic [2:0]              pins;
  logic [STAGES-1:0][2:0]  stg_q;
  logic [STAGES-1:0][2:0]  stg_d;
  logic                    sclk_prev_q;
  logic [2:0]              tail;

  assign pins = {cs_n, sclk, sdi};
  assign tail = stg_q[STAGES-1];

  always_comb begin
    stg_d[0] = pins;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q       <= {STAGES{IDLE_VAL}};
      sclk_prev_q <= 1'b0;
    end else begin
      stg_q       <= stg_d;
      sclk_prev_q <= tail[1];
    end
  end

  always_comb begin
    ev.active = ~tail[2];
    ev.rise   = ~tail[2] & tail[1] & ~sclk_prev_q;
    ev.fall   = ~tail[2] & ~tail[1] & sclk_prev_q;
    ev.din    = tail[0];
  end
endmodule

// File: rtl/spi_regacc_frame.sv
module spi_regacc_frame
  import spi_regacc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = CMD_BITS + DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_ev_t           ev,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              is_read,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re
);
  localparam int SH_W = CMD_BITS;
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              we_q, we_d;
  logic              re_q, re_d;

  always_comb begin
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    if (!ev.active) begin
      cnt_d = '0;
      sh_d  = '0;
      rd_d  = 1'b0;
    end else if (ev.rise && cnt_q != FULL) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = {sh_q[SH_W-2:0], ev.din};
      if (cnt_q == LAST_CMD) begin
        rd_d   = sh_q[SH_W-2];
        re_d   = sh_q[SH_W-2];
        addr_d = sh_d[ADDR_W-1:0];
      end
      if (cnt_q == LAST_DATA && !rd_q) begin
        we_d    = 1'b1;
        wdata_d = sh_d[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      we_q    <= we_d;
      re_q    <= re_d;
    end
  end

  assign bit_cnt   = cnt_q;
  assign is_read   = rd_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;

  AST_RE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    re_q |=> !re_q) else $error("read strobe longer than one cycle"); // R4
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q) else $error("write strobe longer than one cycle"); // R7
  AST_WE_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(cnt_q) == LAST_DATA) else $error("write before full byte"); // R8
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_q && re_q)) else $error("both strobes at once"); // R2
endmodule

// File: rtl/spi_regacc_txout.sv
module spi_regacc_txout
  import spi_regacc_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = CMD_BITS + DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spi_ev_t           ev,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic              is_read,
  input  logic              load,
  input  logic [DATA_W-1:0] rdata,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] FIRST_OUT = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] END_OUT   = CNT_W'(FRAME_BITS);

  logic [DATA_W-1:0] tx_q, tx_d;
  logic              sdo_q, sdo_d;
  logic              oe_q, oe_d;
  logic              fall_ev;
  logic              in_window;

  assign fall_ev   = ev.fall;
  assign in_window = (bit_cnt >= FIRST_OUT) && (bit_cnt < END_OUT);

  always_comb begin
    tx_d  = tx_q;
    sdo_d = sdo_q;
    oe_d  = oe_q;
    if (!ev.active) begin
      oe_d = 1'b0;
    end else begin
      if (load) tx_d = rdata;
      if (ev.fall) begin
        if (is_read && in_window) begin
          oe_d  = 1'b1;
          sdo_d = tx_q[DATA_W-1];
          tx_d  = {tx_q[DATA_W-2:0], 1'b0};
        end else begin
          oe_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      sdo_q <= sdo_d;
      oe_q  <= oe_d;
    end
  end

  assign sdo    = sdo_q & oe_q;
  assign sdo_oe = oe_q;

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.active |=> !oe_q) else $error("sdo enabled while deselected"); // R1
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> is_read) else $error("sdo enabled outside a read"); // R6
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall_ev) |-> $stable(sdo_q)) else $error("sdo moved off a falling edge"); // R5
endmodule

// File: rtl/spi_regacc.sv
module spi_regacc
  import spi_regacc_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;
  spi_ev_t               ev;
  logic [CNT_W-1:0]      bit_cnt;
  logic                  is_read;

  generate
    if (RST_STAGES == 1) begin : g_rst1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= 1'b1;
      end
    end else begin : g_rstn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe_q <= '0;
        else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  spi_regacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .sdi   (sdi),
    .ev    (ev)
  );

  spi_regacc_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ev        (ev),
    .bit_cnt   (bit_cnt),
    .is_read   (is_read),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_re    (reg_re)
  );

  spi_regacc_txout #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ev      (ev),
    .bit_cnt (bit_cnt),
    .is_read (is_read),
    .load    (reg_re),
    .rdata   (reg_rdata),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe)
  );
endmodule

// File: tb/sim_spi_regacc.sv
`timescale 1ns/1ps
module sim_spi_regacc;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe, reg_we, reg_re;
  logic [10:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;

  logic [7:0]  regfile [2048];
  logic [7:0]  ref_mem [2048];
  int          we_cnt = 0, re_cnt = 0;
  logic [10:0] last_waddr = '0, last_raddr = '0;
  logic [7:0]  last_wdata = '0;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  spi_regacc u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = regfile[reg_addr];

  function automatic logic [7:0] seed_val(input int i);
    return 8'(i * 37) ^ 8'h5A;
  endfunction

  always @(negedge clk) begin
    if (reg_we) begin
      we_cnt++;
      last_waddr = reg_addr;
      last_wdata = reg_wdata;
      regfile[reg_addr] = reg_wdata;
    end
    if (reg_re) begin
      re_cnt++;
      last_raddr = reg_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input bit rd, input logic [3:0] ign,
                                         input logic [10:0] a, input logic [7:0] d);
    return {rd, ign, a, d, 8'h00};
  endfunction

  // drives n bits; for reads checks sdo/sdo_oe before each rising edge
  task automatic xfer(input logic [31:0] w, input int n, input bit rd, input logic [7:0] exp);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdi = w[31-i];
      repeat (H) @(negedge clk);
      if (rd && i >= 16 && i < 24) begin
        check(sdo_oe == 1'b1, "R6 oe in read data phase", sdo_oe, 1);
        check(sdo == exp[23-i], "R5 sdo bit", sdo, exp[23-i]);
      end else if (i == 0 || i == 15 || i >= 24 || (!rd && i == 20)) begin
        check(sdo_oe == 1'b0, (i >= 24) ? "R9 oe after frame" : "R6 oe outside read data",
              sdo_oe, 0);
      end
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    if (rd && n >= 24) check(sdo_oe == 1'b0, "R6 oe released after bit 23", sdo_oe, 0);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
    check(sdo_oe == 1'b0, "R1 oe low after deselect", sdo_oe, 0);
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d, input logic [3:0] ign,
                          input int n);
    int wb = we_cnt;
    xfer(mkword(1'b0, ign, a, d), n, 1'b0, 8'h00);
    if (n >= 24) begin
      ref_mem[a] = d;
      check(we_cnt == wb + 1, "R7 one write strobe", we_cnt - wb, 1);
      check(last_waddr == a, "R3 write address", last_waddr, a);
      check(last_wdata == d, "R7 write data", last_wdata, d);
    end else begin
      check(we_cnt == wb, "R8 truncated write dropped", we_cnt - wb, 0);
    end
  endtask

  task automatic do_read(input logic [10:0] a, input logic [3:0] ign, input int n);
    int rb = re_cnt;
    int wb = we_cnt;
    xfer(mkword(1'b1, ign, a, 8'h00), n, 1'b1, ref_mem[a]);
    check(re_cnt == rb + 1, "R4 one read strobe", re_cnt - rb, 1);
    check(last_raddr == a, "R3 read address", last_raddr, a);
    check(we_cnt == wb, "R2 read makes no write", we_cnt - wb, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4711);
    for (int i = 0; i < 2048; i++) begin
      regfile[i] = seed_val(i);
      ref_mem[i] = seed_val(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(sdo_oe == 1'b0, "R1 reset oe", sdo_oe, 0);
    check(reg_we == 1'b0 && reg_re == 1'b0, "R1 reset strobes", {reg_we, reg_re}, 0);

    // R1: serial clock toggling while deselected
    begin
      int wb = we_cnt;
      int rb = re_cnt;
      for (int i = 0; i < 30; i++) begin
        sdi = i[0];
        repeat (H) @(negedge clk); sclk = 1'b1;
        repeat (H) @(negedge clk); sclk = 1'b0;
        if (sdo_oe) check(1'b0, "R1 oe while deselected", 1, 0);
      end
      check(we_cnt == wb && re_cnt == rb, "R1 no strobe while deselected",
            (we_cnt - wb) + (re_cnt - rb), 0);
    end

    // directed corners
    do_write(11'h7FF, 8'hA5, 4'h0, 24);
    do_read (11'h7FF, 4'hF, 24);                 // R3 top address, ignored bits set
    do_write(11'h000, 8'h3C, 4'hF, 24);
    do_read (11'h000, 4'hA, 24);                 // R3 bottom address
    do_write(11'h405, 8'h81, 4'h5, 24);
    do_read (11'h405, 4'h0, 24);                 // R2 MSB-first order
    do_write(11'h405, 8'hFF, 4'h0, 20);          // R8 dropped
    do_read (11'h405, 4'h0, 24);                 // R8 register untouched
    do_write(11'h123, 8'h00, 4'h0, 9);           // R8 very short
    do_write(11'h123, 8'h6E, 4'h0, 24);          // R8 next frame decodes fresh
    do_read (11'h123, 4'h0, 24);
    do_write(11'h2B4, 8'hC3, 4'h3, 30);          // R9 extra bits after write
    do_read (11'h2B4, 4'h0, 28);                 // R9 extra bits after read

    // constrained random
    for (int k = 0; k < 40; k++) begin
      logic [10:0] a;
      logic [7:0]  d;
      logic [3:0]  ig;
      int          sel;
      a   = 11'($urandom);
      d   = 8'($urandom);
      ig  = 4'($urandom);
      sel = int'($urandom_range(0, 9));
      if (sel < 4)       do_write(a, d, ig, 24);
      else if (sel < 5)  do_write(a, d, ig, int'($urandom_range(1, 23)));
      else               do_read(a, ig, 24);
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule